// File: doc/BRIEF.md
# Hamming SEC-DED Memory Word Checker and Corrector

This block protects a 16-bit memory word with a 6-bit check word built from a modified Hamming code. On the write side it produces the check word to be stored next to the data. On the read side it captures the 22-bit word coming back from memory and raises a single-error flag and a double-error flag. A single data-bit error is repaired, and a single check-bit error is flagged with the data left as it was. Any two-bit error is flagged as uncorrectable.

A 2-bit mode input `{mode[1], mode[0]}` sequences the operation, and per-port output enables stand in for bidirectional pins. The read side is used in three steps. Mode 01 presents the memory word. A rise of `mode[1]` while `mode[0]` is high captures the word and enables the flags. Mode 10 then drives the corrected data and the 6-bit syndrome. Check bits 0 and 1 are stored inverted, so a word that is all zeros or all ones is never a valid codeword.

Top module: `edac_secded`

## Requirements
- R1: In mode 00, `chk_oe`=1, `data_oe`=0, `data_out`=0 and `chk_out` is the check word of `data_in`. The check word is the XOR of the column codes of the set data bits, then XOR 6'b000011. The column codes for data bits 0 to 15 are, in hex: 0B,0D,0E,13,15,16,1A,1C,23,25,29,2A,2C,31,32,34.
- R2: A captured 22-bit word of all zeros or all ones raises both flags.
- R3: In mode 01, both output enables are 0 and both `data_out` and `chk_out` are 0.
- R4: The word `{chk_in, data_in}` is captured at a clock edge where the mode is 11 and `mode[1]` was 0 in the previous cycle. Otherwise the captured word holds, including across 10→11 and across input changes while in 10 or 11.
- R5: In modes 00 and 01 both error flags are 0.
- R6: Let the syndrome be the check word of the captured data XOR the captured check word. When it is zero, mode 10 drives the captured data unchanged on `data_out` with `chk_out`=0 and both flags 0.
- R7: When the syndrome equals the column code of data bit i, mode 10 drives the captured data with bit i inverted and `chk_out` = the syndrome, with `err_single`=1 and `err_double`=0.
- R8: When the syndrome has exactly one bit set, mode 10 drives the captured data unchanged and `chk_out` = the syndrome, with `err_single`=1 and `err_double`=0.
- R9: Any other nonzero syndrome sets both flags and leaves the data uncorrected. This covers every two-bit error in the 22-bit word.
- R10: In mode 11, both output enables and both data outputs are 0. The flags reflect the word held in the latch, which changes at the end of the first mode-11 cycle.
- R11: After reset, the latch holds data 0 with check word 000011 (a valid codeword), and `mode[1]` counts as previously low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operation select {S1,S0} |
| data_in | input | 16 | Data word from the bus |
| chk_in | input | 6 | Check word from memory |
| data_out | output | 16 | Corrected data (mode 10) |
| data_oe | output | 1 | Data port drive enable |
| chk_out | output | 6 | Generated check word or syndrome |
| chk_oe | output | 1 | Check port drive enable |
| err_single | output | 1 | An error is present |
| err_double | output | 1 | The error is uncorrectable |

## Verification
The bench builds the block with its defaults: 16 data bits, 6 check bits and an inversion mask of 000011. At that size every one of the 22 single-bit faults and all 231 two-bit faults of a stored word can be injected exhaustively. The all-zero and all-one gross words are included, and a stream of random modes exercises capture ordering, including 10→11 transitions that must not recapture.

// File: rtl/edac_pkg.sv
package edac_pkg;

   typedef enum logic [1:0] {
      MODE_ENCODE  = 2'b00,
      MODE_ACCEPT  = 2'b01,
      MODE_CORRECT = 2'b10,
      MODE_CAPTURE = 2'b11
   } edac_mode_e;

   function automatic int unsigned popcnt(input int unsigned v);
      int unsigned n;
      n = 0;
      for (int b = 0; b < 32; b++) n += (v >> b) & 1;
      return n;
   endfunction

   // balancing exclusions: two complementary pairs of weight-3 codes
   function automatic bit skip_code(input int unsigned v, input int cw);
      return (cw == 6) && (v == 7 || v == 25 || v == 38 || v == 56);
   endfunction

   function automatic int unsigned col_code(input int idx, input int cw);
      int n;
      n = 0;
      for (int unsigned v = 1; v < (1 << cw); v++) begin
         if (popcnt(v) == 3 && !skip_code(v, cw)) begin
            if (n == idx) return v;
            n++;
         end
      end
      return 0;
   endfunction

   function automatic int col_capacity(input int cw);
      int n;
      n = 0;
      for (int unsigned v = 1; v < (1 << cw); v++)
         if (popcnt(v) == 3 && !skip_code(v, cw)) n++;
      return n;
   endfunction

   function automatic logic [63:0] cover_mask(input int row, input int dw, input int cw);
      logic [63:0] m;
      int unsigned code;
      m = '0;
      for (int i = 0; i < dw && i < 64; i++) begin
         code = col_code(i, cw);
         if (((code >> row) & 1) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/edac_encoder.sv
module edac_encoder #(
   parameter int DATA_W = 16,
   parameter int CHK_W  = 6
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  parity
);
   genvar j;
   generate
      for (j = 0; j < CHK_W; j++) begin : g_row
         localparam logic [DATA_W-1:0] ROW_MASK =
            DATA_W'(edac_pkg::cover_mask(j, DATA_W, CHK_W));
         assign parity[j] = ^(data & ROW_MASK);
      end
   endgenerate
endmodule

// File: rtl/edac_word_latch.sv
module edac_word_latch #(
   parameter int          W       = 22,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] word_in,
   output logic [W-1:0] word_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= RST_VAL;
      else if (capture) word_q <= word_in;
   end
endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode #(
   parameter int DATA_W = 16,
   parameter int CHK_W  = 6
) (
   input  logic [CHK_W-1:0]  syn,
   input  logic [DATA_W-1:0] data_raw,
   output logic [DATA_W-1:0] data_fix,
   output logic              err_any,
   output logic              err_multi
);
   logic [DATA_W-1:0] match;
   logic              chk_bit_only;
   logic              fixable;

   genvar i;
   generate
      for (i = 0; i < DATA_W; i++) begin : g_col
         localparam logic [CHK_W-1:0] COL = CHK_W'(edac_pkg::col_code(i, CHK_W));
         assign match[i] = (syn == COL);
      end
   endgenerate

   always_comb begin
      chk_bit_only = ($countones(syn) == 1);
      fixable      = |match;
      err_any      = |syn;
      err_multi    = err_any && !chk_bit_only && !fixable;
      data_fix     = data_raw ^ match;
   end

   always_comb begin
      if (!$isunknown(syn)) begin
         // R7
         flip_onehot_chk: assert ($onehot0(match));
         // R8
         chkbit_nofix_chk: assert (!chk_bit_only || data_fix == data_raw);
      end
   end
endmodule

// File: rtl/edac_secded.sv
module edac_secded #(
   parameter int               DATA_W   = 16,
   parameter int               CHK_W    = 6,
   parameter logic [CHK_W-1:0] INV_MASK = 6'b000011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] data_in,
   input  logic [CHK_W-1:0]  chk_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic [CHK_W-1:0]  chk_out,
   output logic              chk_oe,
   output logic              err_single,
   output logic              err_double
);
   import edac_pkg::*;

   localparam int WORD_W = DATA_W + CHK_W;
   localparam logic [WORD_W-1:0] LATCH_RST = {INV_MASK, {DATA_W{1'b0}}};

   initial begin
      width_cap_chk: assert (DATA_W <= col_capacity(CHK_W) && DATA_W <= 64)
         else $fatal(1, "edac_secded: DATA_W too large for CHK_W");
      chk_min_chk: assert (CHK_W >= 3)
         else $fatal(1, "edac_secded: CHK_W below 3");
   end

   edac_mode_e        mode_e;
   logic              prev_s1;
   logic              capture;
   logic [WORD_W-1:0] lat_word;
   logic [DATA_W-1:0] lat_data;
   logic [CHK_W-1:0]  lat_chk;
   logic [CHK_W-1:0]  par_wr, par_rd, syn;
   logic [DATA_W-1:0] data_fix;
   logic              flag_any, flag_multi;

   assign mode_e  = edac_mode_e'(mode);
   assign capture = (mode_e == MODE_CAPTURE) && !prev_s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_s1 <= 1'b0;
      else        prev_s1 <= mode[1];
   end

   edac_word_latch #(.W(WORD_W), .RST_VAL(LATCH_RST)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .word_in ({chk_in, data_in}),
      .word_q  (lat_word)
   );

   assign lat_data = lat_word[DATA_W-1:0];
   assign lat_chk  = lat_word[WORD_W-1:DATA_W];

   edac_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_wr (
      .data   (data_in),
      .parity (par_wr)
   );

   edac_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_rd (
      .data   (lat_data),
      .parity (par_rd)
   );

   assign syn = par_rd ^ INV_MASK ^ lat_chk;

   edac_syn_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .syn       (syn),
      .data_raw  (lat_data),
      .data_fix  (data_fix),
      .err_any   (flag_any),
      .err_multi (flag_multi)
   );

   always_comb begin
      data_out   = '0;
      chk_out    = '0;
      data_oe    = 1'b0;
      chk_oe     = 1'b0;
      err_single = 1'b0;
      err_double = 1'b0;
      unique case (mode_e)
         MODE_ENCODE: begin
            chk_oe  = 1'b1;
            chk_out = par_wr ^ INV_MASK;
         end
         MODE_ACCEPT: ;
         MODE_CAPTURE: begin
            err_single = flag_any;
            err_double = flag_multi;
         end
         MODE_CORRECT: begin
            data_oe    = 1'b1;
            chk_oe     = 1'b1;
            data_out   = data_fix;
            chk_out    = syn;
            err_single = flag_any;
            err_double = flag_multi;
         end
      endcase
   end

   // R9
   dbl_implies_sgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_double |-> err_single);

   // R5
   idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |-> (!err_single && !err_double));

   // R4
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(lat_word));

   // R4
   latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (lat_word == $past({chk_in, data_in})));

   // R10
   oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (chk_oe && mode == 2'b10));

endmodule

// File: tb/edac_secded_tb.sv
module edac_secded_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [1:0]  mode  = 2'b01;
   logic [15:0] din   = '0;
   logic [5:0]  cin   = '0;
   logic [15:0] data_out;
   logic        data_oe;
   logic [5:0]  chk_out;
   logic        chk_oe;
   logic        err_single, err_double;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   string tag_ovr = "";

   localparam logic [5:0] INV = 6'b000011;
   logic [5:0] cols [16] = '{6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h1A, 6'h1C,
                             6'h23, 6'h25, 6'h29, 6'h2A, 6'h2C, 6'h31, 6'h32, 6'h34};

   logic [15:0] m_d = 16'h0000;
   logic [5:0]  m_c = INV;
   bit          m_prev = 0;

   edac_secded u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .data_in(din), .chk_in(cin),
      .data_out(data_out), .data_oe(data_oe), .chk_out(chk_out), .chk_oe(chk_oe),
      .err_single(err_single), .err_double(err_double)
   );

   function automatic logic [5:0] enc(input logic [15:0] d);
      logic [5:0] r;
      r = INV;
      for (int i = 0; i < 16; i++) if (d[i]) r ^= cols[i];
      return r;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input logic [1:0] m, input logic [15:0] d);
      logic [5:0]  syn;
      logic [15:0] fixed;
      bit es, ed;
      int hit;
      string t;
      syn = enc(m_d) ^ m_c;
      fixed = m_d; es = 0; ed = 0; t = "R6";
      if (syn != 0) begin
         es = 1;
         if ($countones(syn) == 1) t = "R8";
         else begin
            hit = -1;
            for (int i = 0; i < 16; i++) if (cols[i] == syn) hit = i;
            if (hit >= 0) begin fixed[hit] = ~fixed[hit]; t = "R7"; end
            else begin ed = 1; t = "R9"; end
         end
      end
      case (m)
         2'b00: begin
            t = (tag_ovr != "") ? tag_ovr : "R1";
            chk(t, "data_oe", 32'(data_oe), 0);
            chk(t, "chk_oe", 32'(chk_oe), 1);
            chk(t, "chk_out", 32'(chk_out), 32'(enc(d)));
            chk(t, "data_out", 32'(data_out), 0);
            chk("R5", "flags", {30'd0, err_single, err_double}, 0);
         end
         2'b01: begin
            t = (tag_ovr != "") ? tag_ovr : "R3";
            chk(t, "oe", {30'd0, data_oe, chk_oe}, 0);
            chk(t, "outs", {10'd0, chk_out, data_out}, 0);
            chk("R5", "flags", {30'd0, err_single, err_double}, 0);
         end
         2'b11: begin
            t = (tag_ovr != "") ? tag_ovr : "R10";
            chk(t, "oe", {30'd0, data_oe, chk_oe}, 0);
            chk(t, "outs", {10'd0, chk_out, data_out}, 0);
            chk(t, "flags", {30'd0, err_single, err_double}, {30'd0, es, ed});
         end
         default: begin
            if (tag_ovr != "") t = tag_ovr;
            chk(t, "oe", {30'd0, data_oe, chk_oe}, 3);
            chk(t, "data_out", 32'(data_out), 32'(fixed));
            chk(t, "syndrome", 32'(chk_out), 32'(syn));
            chk(t, "flags", {30'd0, err_single, err_double}, {30'd0, es, ed});
         end
      endcase
   endtask

   task automatic step(input logic [1:0] m, input logic [15:0] d, input logic [5:0] c);
      @(negedge clk);
      mode = m; din = d; cin = c;
      #2;
      compare(m, d);
      @(posedge clk);
      if (m == 2'b11 && !m_prev) begin m_d = d; m_c = c; end
      m_prev = m[1];
   endtask

   task automatic read_word(input logic [15:0] d, input logic [5:0] c, input string t);
      tag_ovr = "";
      step(2'b01, d, c);
      step(2'b11, d, c);
      step(2'b11, ~d, ~c);
      tag_ovr = t;
      step(2'b10, ~d, ~c);
      tag_ovr = "R4";
      step(2'b11, d ^ 16'h0F0F, c ^ 6'h15);
      step(2'b10, 16'h0000, 6'h00);
      tag_ovr = "";
      step(2'b01, d, c);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL R4 watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] base;
      logic [21:0] w;
      logic [31:0] lcg;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R11: reset contents seen through the correction mode
      tag_ovr = "R11";
      step(2'b10, 16'hFFFF, 6'h3F);
      tag_ovr = "";
      step(2'b01, 16'h0000, 6'h00);

      // R1: encoder on fixed and one-hot words
      step(2'b00, 16'h0000, 6'h00);
      step(2'b00, 16'hFFFF, 6'h00);
      step(2'b00, 16'hA5A5, 6'h3F);
      step(2'b00, 16'h5A5A, 6'h00);
      for (int i = 0; i < 16; i++) step(2'b00, 16'(1) << i, 6'h00);

      // R6: clean reads
      read_word(16'h0000, enc(16'h0000), "R6");
      read_word(16'hBEEF, enc(16'hBEEF), "R6");
      read_word(16'h1357, enc(16'h1357), "R6");

      // R7 / R8: every single fault of the 22-bit word
      base = 16'hC3A1;
      for (int k = 0; k < 22; k++) begin
         w = {enc(base), base};
         w[k] = ~w[k];
         read_word(w[15:0], w[21:16], (k < 16) ? "R7" : "R8");
      end

      // R9: every double fault
      base = 16'h6D12;
      for (int a = 0; a < 22; a++)
         for (int b = a + 1; b < 22; b++) begin
            w = {enc(base), base};
            w[a] = ~w[a];
            w[b] = ~w[b];
            read_word(w[15:0], w[21:16], "R9");
         end

      // R2: gross words
      read_word(16'h0000, 6'h00, "R2");
      read_word(16'hFFFF, 6'h3F, "R2");

      // random mode stream
      lcg = 32'h1234_5678;
      for (int n = 0; n < 600; n++) begin
         logic [15:0] rd;
         logic [5:0]  rc;
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         rd = lcg[31:16];
         rc = (lcg[9:8] == 2'b00) ? lcg[15:10] : enc(rd) ^ (6'(lcg[12]) << lcg[15:13]);
         step(lcg[5:4], rd, rc);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule